// File: doc/BRIEF.md
# Serial EEPROM Two-Wire Slave Engine

This block is the bus side of a byte-wide serial EEPROM. It watches a two-wire bus (clock and open-drain data, both already synchronized to the system clock), recognizes start and stop conditions and decodes the select byte. The select byte picks either the main byte array or a small, separate identification page. The block then takes in a two-byte word address and either collects written bytes or streams stored bytes back to the master. It answers every byte with an acknowledge or leaves the line released, and it only ever pulls the data line low.

Written bytes are held in a page buffer and are committed to storage when a stop closes the transfer. After the commit the block runs a timed internal write cycle. During that cycle it ignores the bus completely. A write-protect input leaves the select and address phases untouched but refuses every data byte. Two strap inputs give the block its bus identity, so several devices can share one bus.

The storage is a reduced internal array of 2^MEM_AW bytes. It is indexed by address bit 16 followed by the low MEM_AW-1 address bits. The identification page is indexed by the low ID_AW address bits.

Top module: `i2cee_slave`

## Requirements
- R1: A falling data edge while the clock is high is a start. It begins a new transfer from any state, including a repeated start. A rising data edge while the clock is high is a stop. It ends the transfer, and the data line is released on the clock after a stop.
- R2: Select byte, bit 7 sent first: bits 7..4 are the type, bit 3 must equal strap ce2_i, bit 2 must equal strap ce1_i, bit 1 is address bit 16, and bit 0 is read (1) or write (0). Type 1010 selects the main array and type 1011 selects the identification page. Any other type or a strap mismatch is not acknowledged, and the block stays silent until the next start.
- R3: For every byte it accepts, the block pulls data low for the whole ninth clock. Bits are taken on rising clock edges, most significant bit first.
- R4: After a write select, the next two bytes are address bits 15..8 and then bits 7..0, and both are acknowledged. Bit 16 comes from the select byte.
- R5: Data bytes after the address go into a page buffer of 2^PG_AW bytes. The low PG_AW address bits advance after each byte and wrap within the page, and the upper bits stay fixed.
- R6: While wp_i is 1, select and address bytes are still acknowledged, but data bytes are neither acknowledged nor stored. A following stop starts no write cycle.
- R7: A stop with buffered data commits the data and raises busy_o for exactly WR_CYCLES clocks. During that time no byte is acknowledged and starts are ignored.
- R8: After a read select, the block drives stored bytes MSB first, beginning at the current address. It releases data during the master's acknowledge clock. Each byte the master acknowledges advances the 17-bit address by one.
- R9: A master no-acknowledge on a read byte returns the block to idle with data released. A stop followed by a new start then works normally.
- R10: The identification page is separate storage. A write to it leaves main-array bytes unchanged, and the reverse also holds.
- R11: sda_oe_o only rises while the bus clock is low.
- R12: After reset, sda_oe_o and busy_o are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronized bus clock |
| sda_i | input | 1 | Synchronized bus data (resolved line level) |
| ce1_i | input | 1 | Identity strap compared with select bit 2 |
| ce2_i | input | 1 | Identity strap compared with select bit 3 |
| wp_i | input | 1 | Write protect, 1 refuses data bytes |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| busy_o | output | 1 | Internal write cycle in progress |

## Verification
Select bytes are tried with the matching code, a wrong strap bit and a foreign type, which shows whether the decode compares all six upper bits. Page writes start near the end of a page so that the wrap lands on the first bytes of the same page rather than the next one. Reads are done at identical offsets in both stores and with address bit 16 set and clear, which separates the two stores and the two array halves. Write-protected and busy-period transfers are each followed by a readback, so that a refused byte is shown to be missing from storage and not just unacknowledged.

// File: rtl/i2cee_pkg.sv
package i2cee_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEV,
    PH_AHI,
    PH_ALO,
    PH_WDAT,
    PH_RDAT
  } phase_t;

  localparam logic [3:0] TYPE_MAIN = 4'b1010;
  localparam logic [3:0] TYPE_ID   = 4'b1011;
  localparam int         ADDR_W    = 17;
endpackage

// File: rtl/i2cee_busmon.sv
module i2cee_busmon (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign start_o = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o  = scl_i & scl_q & ~sda_q & sda_i;
  assign rise_o  = scl_i & ~scl_q;
  assign fall_o  = ~scl_i & scl_q;
endmodule

// File: rtl/i2cee_wrtimer.sv
module i2cee_wrtimer #(
  parameter int WR_CYCLES = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go_i,
  output logic busy_o
);
  localparam int CW = $clog2(WR_CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (go_i)            cnt_d = CW'(WR_CYCLES);
    else if (cnt_q != 0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy_o = (cnt_q != 0);
endmodule

// File: rtl/i2cee_store.sv
module i2cee_store #(
  parameter int MEM_AW = 10,
  parameter int ID_AW  = 8,
  parameter int PG_AW  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr_i,
  input  logic                  buf_we_i,
  input  logic [PG_AW-1:0]      buf_idx_i,
  input  logic [7:0]            buf_data_i,
  input  logic [16-PG_AW:0]     buf_base_i,
  input  logic                  buf_sel_id_i,
  input  logic                  commit_i,
  input  logic [16:0]           rd_addr_i,
  input  logic                  rd_sel_id_i,
  output logic [7:0]            rd_data_o,
  output logic                  buf_any_o
);
  localparam int PG = 1 << PG_AW;
  localparam int MD = 1 << MEM_AW;
  localparam int ID = 1 << ID_AW;

  logic [7:0]          main_mem [MD];
  logic [7:0]          id_mem   [ID];
  logic [7:0]          pg_data  [PG];
  logic [PG-1:0]       pg_val_q;
  logic [16-PG_AW:0]   base_q;
  logic                sel_q;

  function automatic logic [MEM_AW-1:0] main_idx(input logic [16:0] a);
    return {a[16], a[MEM_AW-2:0]};
  endfunction

  function automatic logic [ID_AW-1:0] id_idx(input logic [16:0] a);
    return a[ID_AW-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_val_q <= '0;
      base_q   <= '0;
      sel_q    <= 1'b0;
    end else if (clr_i || commit_i) begin
      pg_val_q <= '0;
    end else if (buf_we_i) begin
      pg_val_q[buf_idx_i] <= 1'b1;
      base_q              <= buf_base_i;
      sel_q               <= buf_sel_id_i;
    end
  end

  always_ff @(posedge clk) begin
    if (buf_we_i) pg_data[buf_idx_i] <= buf_data_i;
  end

  always_ff @(posedge clk) begin
    if (commit_i) begin
      for (int i = 0; i < PG; i++) begin
        if (pg_val_q[i]) begin
          if (sel_q) id_mem[id_idx({base_q, PG_AW'(i)})]     <= pg_data[i];
          else       main_mem[main_idx({base_q, PG_AW'(i)})] <= pg_data[i];
        end
      end
    end
  end

  assign rd_data_o = rd_sel_id_i ? id_mem[id_idx(rd_addr_i)]
                                 : main_mem[main_idx(rd_addr_i)];
  assign buf_any_o = |pg_val_q;
endmodule

// File: rtl/i2cee_slave.sv
module i2cee_slave
  import i2cee_pkg::*;
#(
  parameter int MEM_AW    = 10,
  parameter int ID_AW     = 8,
  parameter int PG_AW     = 4,
  parameter int WR_CYCLES = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic ce1_i,
  input  logic ce2_i,
  input  logic wp_i,
  output logic sda_oe_o,
  output logic busy_o
);
  logic rst_meta, rst_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  logic start_ev, stop_ev, rise_ev, fall_ev;

  i2cee_busmon u_mon (
    .clk(clk), .rst_n(rst_sync), .scl_i(scl_i), .sda_i(sda_i),
    .start_o(start_ev), .stop_o(stop_ev), .rise_o(rise_ev), .fall_o(fall_ev)
  );

  phase_t      phase_q, phase_d;
  logic [3:0]  cnt_q, cnt_d;
  logic [7:0]  sh_q, sh_d;
  logic [7:0]  rdb_q, rdb_d;
  logic [16:0] addr_q, addr_d;
  logic        oe_q, oe_d;
  logic        sel_id_q, sel_id_d;
  logic        rw_q, rw_d;
  logic        mack_q, mack_d;

  logic        buf_we, commit, clr, buf_any, busy;
  logic [7:0]  rd_data;
  logic [16:0] rd_addr;
  logic [7:0]  rd_shift;
  logic        sel_ok;

  assign rd_addr  = (phase_q == PH_RDAT) ? addr_q + 17'd1 : addr_q;
  assign rd_shift = rdb_q << cnt_q;
  assign sel_ok   = ((sh_q[7:4] == TYPE_MAIN) || (sh_q[7:4] == TYPE_ID)) &&
                    (sh_q[3] == ce2_i) && (sh_q[2] == ce1_i);

  always_comb begin
    phase_d  = phase_q;
    cnt_d    = cnt_q;
    sh_d     = sh_q;
    rdb_d    = rdb_q;
    addr_d   = addr_q;
    oe_d     = oe_q;
    sel_id_d = sel_id_q;
    rw_d     = rw_q;
    mack_d   = mack_q;
    buf_we   = 1'b0;
    commit   = 1'b0;
    clr      = 1'b0;
    if (!busy) begin
      if (start_ev) begin
        phase_d = PH_DEV;
        cnt_d   = '0;
        oe_d    = 1'b0;
        clr     = 1'b1;
      end else if (stop_ev) begin
        phase_d = PH_IDLE;
        oe_d    = 1'b0;
        commit  = buf_any;
      end else if (phase_q != PH_IDLE) begin
        if (rise_ev) begin
          if (cnt_q < 4'd8)  sh_d   = {sh_q[6:0], sda_i};
          if (cnt_q == 4'd8) mack_d = ~sda_i;
          if (cnt_q < 4'd9)  cnt_d  = cnt_q + 4'd1;
        end else if (fall_ev) begin
          if (cnt_q == 4'd8) begin
            unique case (phase_q)
              PH_DEV: begin
                if (sel_ok) begin
                  oe_d       = 1'b1;
                  sel_id_d   = (sh_q[7:4] == TYPE_ID);
                  addr_d[16] = sh_q[1];
                  rw_d       = sh_q[0];
                end else begin
                  phase_d = PH_IDLE;
                end
              end
              PH_AHI: begin
                oe_d          = 1'b1;
                addr_d[15:8]  = sh_q;
              end
              PH_ALO: begin
                oe_d          = 1'b1;
                addr_d[7:0]   = sh_q;
              end
              PH_WDAT: begin
                if (!wp_i) begin
                  oe_d   = 1'b1;
                  buf_we = 1'b1;
                  addr_d = {addr_q[16:PG_AW], addr_q[PG_AW-1:0] + 1'b1};
                end
              end
              default: oe_d = 1'b0;
            endcase
          end else if (cnt_q == 4'd9) begin
            oe_d  = 1'b0;
            cnt_d = '0;
            unique case (phase_q)
              PH_DEV: begin
                if (rw_q) begin
                  phase_d = PH_RDAT;
                  rdb_d   = rd_data;
                  oe_d    = ~rd_data[7];
                end else begin
                  phase_d = PH_AHI;
                end
              end
              PH_AHI: phase_d = PH_ALO;
              PH_ALO: phase_d = PH_WDAT;
              PH_RDAT: begin
                if (mack_q) begin
                  addr_d = addr_q + 17'd1;
                  rdb_d  = rd_data;
                  oe_d   = ~rd_data[7];
                end else begin
                  phase_d = PH_IDLE;
                end
              end
              default: phase_d = phase_q;
            endcase
          end else if (phase_q == PH_RDAT && cnt_q != 4'd0) begin
            oe_d = ~rd_shift[7];
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      phase_q  <= PH_IDLE;
      cnt_q    <= '0;
      sh_q     <= '0;
      rdb_q    <= '0;
      addr_q   <= '0;
      oe_q     <= 1'b0;
      sel_id_q <= 1'b0;
      rw_q     <= 1'b0;
      mack_q   <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      cnt_q    <= cnt_d;
      sh_q     <= sh_d;
      rdb_q    <= rdb_d;
      addr_q   <= addr_d;
      oe_q     <= oe_d;
      sel_id_q <= sel_id_d;
      rw_q     <= rw_d;
      mack_q   <= mack_d;
    end
  end

  i2cee_store #(.MEM_AW(MEM_AW), .ID_AW(ID_AW), .PG_AW(PG_AW)) u_store (
    .clk(clk), .rst_n(rst_sync), .clr_i(clr),
    .buf_we_i(buf_we), .buf_idx_i(addr_q[PG_AW-1:0]), .buf_data_i(sh_q),
    .buf_base_i(addr_q[16:PG_AW]), .buf_sel_id_i(sel_id_q),
    .commit_i(commit), .rd_addr_i(rd_addr), .rd_sel_id_i(sel_id_q),
    .rd_data_o(rd_data), .buf_any_o(buf_any)
  );

  i2cee_wrtimer #(.WR_CYCLES(WR_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_sync), .go_i(commit), .busy_o(busy)
  );

  assign sda_oe_o = oe_q;
  assign busy_o   = busy;
endmodule

// File: rtl/i2cee_slave_chk.sv
module i2cee_slave_chk #(
  parameter int WR_CYCLES = 400
) (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic sda_i,
  input logic sda_oe_o,
  input logic busy_o
);
  logic        scl_q, sda_q;
  logic [31:0] bcnt;
  logic        stop_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
      bcnt  <= '0;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
      bcnt  <= busy_o ? bcnt + 32'd1 : 32'd0;
    end
  end

  assign stop_w = scl_i & scl_q & ~sda_q & sda_i;

  a_r1_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_w |=> !sda_oe_o);

  a_r7_silent_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !sda_oe_o);

  a_r7_busy_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(stop_w));

  a_r7_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (bcnt == WR_CYCLES));

  a_r11_pull_on_low_clock: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> !scl_i);
endmodule

bind i2cee_slave i2cee_slave_chk #(.WR_CYCLES(WR_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
  .sda_oe_o(sda_oe_o), .busy_o(busy_o)
);

// File: tb/sim_i2cee_slave.sv
`timescale 1ns/1ps
module sim_i2cee_slave;
  localparam int WR_CYCLES = 400;
  localparam int Q = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic wp = 1'b0;
  logic sda_oe, busy;
  logic sda_bus;
  int   checks = 0;
  int   failures = 0;
  int   busy_cycles = 0;

  always #4 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe;

  i2cee_slave #(.WR_CYCLES(WR_CYCLES)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .ce1_i(1'b0), .ce2_i(1'b1), .wp_i(wp),
    .sda_oe_o(sda_oe), .busy_o(busy)
  );

  always @(negedge clk) if (busy) busy_cycles++;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q);
    acked = ~sda_bus;
    tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input logic ack, output logic [7:0] d);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tick(Q); scl = 1'b1; tick(Q);
      d = {d[6:0], sda_bus};
      tick(Q); scl = 1'b0; tick(Q);
    end
    sda_m = ~ack; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 2000) begin tick(1); n++; end
  endtask

  // write select, two address bytes, n data bytes; checks acks
  task automatic write_tx(input string req, input logic [7:0] sel, input logic [7:0] ah,
                          input logic [7:0] al, input logic [7:0] d [4], input int n,
                          input logic exp_data_ack);
    logic a;
    bus_start();
    send_byte(sel, a); chk({req, " select ack"}, a, 1);
    send_byte(ah, a);  chk({req, " R4 addr hi ack"}, a, 1);
    send_byte(al, a);  chk({req, " R4 addr lo ack"}, a, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(d[i], a); chk({req, " data ack"}, a, exp_data_ack);
    end
    busy_cycles = 0;
    bus_stop();
  endtask

  task automatic read_tx(input string req, input logic [7:0] sel, input logic [7:0] ah,
                         input logic [7:0] al, input logic [7:0] e [4], input int n);
    logic a;
    logic [7:0] d;
    bus_start();
    send_byte(sel & 8'hFE, a); chk({req, " R8 dummy select ack"}, a, 1);
    send_byte(ah, a); chk({req, " R8 addr hi ack"}, a, 1);
    send_byte(al, a); chk({req, " R8 addr lo ack"}, a, 1);
    bus_start();
    send_byte(sel | 8'h01, a); chk({req, " R1 repeated start read ack"}, a, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, d);
      chk({req, " R8 read byte"}, {24'h0, d}, {24'h0, e[i]});
    end
    tick(2);
    chk({req, " R9 released after nack"}, sda_oe, 0);
    bus_stop();
    tick(1);
    chk({req, " R1 released after stop"}, sda_oe, 0);
  endtask

  task automatic t_reset();
    chk("R12 sda_oe after reset", sda_oe, 0);
    chk("R12 busy after reset", busy, 0);
  endtask

  task automatic t_page_write();
    write_tx("R3 R5 main write", 8'hA8, 8'h01, 8'h24, '{8'h11, 8'h22, 8'h33, 8'h00}, 3, 1);
    tick(1);
    chk("R7 busy after write stop", busy, 1);
    wait_idle();
    chk("R7 write cycle length", busy_cycles, WR_CYCLES);
    read_tx("R8 sequential read", 8'hA8, 8'h01, 8'h24, '{8'h11, 8'h22, 8'h33, 8'h00}, 3);
  endtask

  task automatic t_bad_select();
    logic a;
    bus_start(); send_byte(8'hA0, a); chk("R2 strap mismatch nack", a, 0);
    send_byte(8'h01, a); chk("R2 silent after mismatch", a, 0);
    bus_stop();
    bus_start(); send_byte(8'hC8, a); chk("R2 foreign type nack", a, 0);
    bus_stop();
    tick(2);
    chk("R2 no write cycle", busy, 0);
  endtask

  task automatic t_id_page();
    logic a;
    write_tx("R10 id write", 8'hB8, 8'h01, 8'h24, '{8'h5A, 8'h00, 8'h00, 8'h00}, 1, 1);
    bus_start(); send_byte(8'hA9, a);
    chk("R7 no ack while busy", a, 0);
    bus_stop();
    wait_idle();
    read_tx("R10 id readback", 8'hB8, 8'h01, 8'h24, '{8'h5A, 8'h00, 8'h00, 8'h00}, 1);
    read_tx("R10 main untouched", 8'hA8, 8'h01, 8'h24, '{8'h11, 8'h00, 8'h00, 8'h00}, 1);
  endtask

  task automatic t_wrap();
    write_tx("R5 wrap write", 8'hA8, 8'h02, 8'h0E, '{8'hA1, 8'hB2, 8'hC3, 8'hD4}, 4, 1);
    tick(1);
    wait_idle();
    read_tx("R5 wrapped to page start", 8'hA8, 8'h02, 8'h00, '{8'hC3, 8'hD4, 8'h00, 8'h00}, 2);
    read_tx("R5 page end bytes", 8'hA8, 8'h02, 8'h0E, '{8'hA1, 8'hB2, 8'h00, 8'h00}, 2);
  endtask

  task automatic t_wp();
    wp = 1'b1;
    write_tx("R6 protected", 8'hA8, 8'h01, 8'h24, '{8'h77, 8'h00, 8'h00, 8'h00}, 1, 0);
    tick(3);
    chk("R6 no write cycle", busy, 0);
    wp = 1'b0;
    read_tx("R6 data unchanged", 8'hA8, 8'h01, 8'h24, '{8'h11, 8'h00, 8'h00, 8'h00}, 1);
  endtask

  task automatic t_a16();
    write_tx("R4 upper half write", 8'hAA, 8'h01, 8'h24, '{8'h99, 8'h00, 8'h00, 8'h00}, 1, 1);
    tick(1);
    wait_idle();
    read_tx("R4 upper half read", 8'hAA, 8'h01, 8'h24, '{8'h99, 8'h00, 8'h00, 8'h00}, 1);
    read_tx("R4 lower half kept", 8'hA8, 8'h01, 8'h24, '{8'h11, 8'h00, 8'h00, 8'h00}, 1);
  endtask

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(5);
    t_reset();
    t_page_write();
    t_bad_select();
    t_id_page();
    t_wrap();
    t_wp();
    t_a16();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    tick(150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule